// File: doc/BRIEF.md
# Gated Debounced Power Button

This block sits between a mechanical, active-low power switch and the chipset's active-low power-button input. It resynchronises the switch, the lid sense and the adapter sense into the clock domain. It ignores the switch whenever the lid is shut and the adapter is absent. It accepts a press only if the switch still reads pressed after a fixed settling wait. A press that fails this second look is dropped and flagged for one cycle.

When a press is confirmed while the platform reports the deep-standby state, the block first asks the rail sequencer to power up. It keeps the button line released until the sequencer has taken the request and gone idle again, and only then passes the press on. In any other platform state a confirmed press goes straight through. A release always passes straight through.

The controller has four states. `ST_IDLE` forwards releases and watches for a new press. `ST_CONFIRM` runs the settling timer. `ST_REQUEST` holds the power-up request. `ST_SEQWAIT` waits for the sequencer to finish.

The transitions are as follows. IDLE→CONFIRM happens on a new press. CONFIRM→IDLE happens when the timer expires and the press is either rejected, or confirmed in a state other than deep standby. CONFIRM→REQUEST happens when the timer expires, the press is confirmed and the platform is in deep standby. REQUEST→SEQWAIT happens when the sequencer reports busy. SEQWAIT→IDLE happens when the sequencer is no longer busy.

Top module: `pwrbtn_gate`

## Requirements
- R1: After reset `btn_n` is high, `pwrup_req` is low and `spurious` is low.
- R2: While `lid_open` is low (lid shut) and `ac_absent` is high, the switch is treated as released. Either condition alone does not mask it.
- R3: A new press is one where the conditioned switch reads low while the forwarded button is high. It starts a wait of `CONFIRM_CYCLES` clocks, and the conditioned level is re-sampled at the end of that wait. A press is confirmed only if the level is still low at that point.
- R4: A press whose re-sample reads high raises `spurious` for exactly one cycle and leaves `btn_n` high.
- R5: Switch activity during the wait neither restarts it nor starts a second one. The decision is taken at the time set by the first press.
- R6: A press confirmed while `plat_state` equals 3'b001 (deep standby) raises `pwrup_req`. The request stays high until `seq_busy` is seen high, then drops.
- R7: After a power-up request, `btn_n` stays high while `seq_busy` is high. It goes low on the first clock edge at which `seq_busy` is sampled low.
- R8: A press confirmed in any other `plat_state` drives `btn_n` low on the decision edge.
- R9: While idle, a conditioned level of high drives `btn_n` high on the next edge, so releases are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_n | input | 1 | Raw power switch, low when pressed |
| lid_open | input | 1 | Lid sense, high when open |
| ac_absent | input | 1 | Adapter sense, high when no adapter |
| plat_state | input | 3 | Platform power state code, 3'b001 = deep standby |
| seq_busy | input | 1 | Rail sequencer is powering up |
| btn_n | output | 1 | Conditioned button to chipset, low when pressed |
| pwrup_req | output | 1 | Request to power up the rails |
| spurious | output | 1 | One-cycle pulse on a rejected press |

## Verification
The bench drives short glitches and bounces that end released. A design that forwarded on the falling edge alone would pass these through as presses instead of flagging them. A bounce that ends pressed checks the decision time: a design that restarts its timer on each new low would confirm the press too late. Lid and adapter combinations are swept, including masking that appears mid-wait, so a design that applies the mask with OR instead of AND would block genuine presses. The deep-standby path checks that the press is held back for the whole busy window and released on the exact edge after busy drops. An early release here would hand the chipset a press before its rails are up.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_REQUEST,
        ST_SEQWAIT
    } btn_state_e;

    localparam logic [2:0] PLAT_DEEP_STANDBY = 3'b001;

endpackage

// File: rtl/pwrbtn_sync.sv
module pwrbtn_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/pwrbtn_timer.sv
module pwrbtn_timer #(
    parameter int unsigned CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic expire
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign running = (cnt_q != '0);
    assign expire  = (cnt_q == CW'(1));

    initial assert (CYCLES >= 2) else $error("CYCLES must be at least 2");

    // R3: a freshly loaded wait does not expire on the next cycle
    assert_no_early_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && !expire));

    // R3: after expiry the timer is idle unless restarted
    assert_stop_after_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !running);

endmodule

// File: rtl/pwrbtn_fsm.sv
module pwrbtn_fsm
    import pwrbtn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cond_n,
    input  logic [2:0] plat_state,
    input  logic       seq_busy,
    input  logic       tmr_running,
    input  logic       tmr_expire,
    output logic       tmr_start,
    output logic       btn_n,
    output logic       pwrup_req,
    output logic       spurious
);
    btn_state_e state_q, state_d;
    logic       btn_q;
    logic       spur_q;
    logic       in_standby;

    assign in_standby = (plat_state == PLAT_DEEP_STANDBY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cond_n && btn_q) begin
                    tmr_start = 1'b1;
                    state_d   = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (tmr_expire) begin
                    if (!cond_n && in_standby) state_d = ST_REQUEST;
                    else                       state_d = ST_IDLE;
                end
            end
            ST_REQUEST: begin
                if (seq_busy) state_d = ST_SEQWAIT;
            end
            ST_SEQWAIT: begin
                if (!seq_busy) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btn_q  <= 1'b1;
            spur_q <= 1'b0;
        end else begin
            spur_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cond_n) btn_q <= 1'b1;
                end
                ST_CONFIRM: begin
                    if (tmr_expire) begin
                        if (cond_n)           spur_q <= 1'b1;
                        else if (!in_standby) btn_q  <= 1'b0;
                    end
                end
                ST_REQUEST: ;
                ST_SEQWAIT: begin
                    if (!seq_busy) btn_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign btn_n     = btn_q;
    assign spurious  = spur_q;
    assign pwrup_req = (state_q == ST_REQUEST);

    // R4: rejection pulse lasts one cycle and never coincides with a press
    assert_spurious_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |=> !spurious);
    assert_spurious_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |-> btn_n);

    // R5: the confirm state is only occupied while the timer runs
    assert_confirm_timed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM) |-> tmr_running);

    // R6: a power-up request follows a standby decision
    assert_req_in_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrup_req) |-> $past(in_standby));

    // R7: the button stays released while rails are sequencing
    assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrup_req || (state_q == ST_SEQWAIT)) |-> btn_n);

    // R9: released level in idle is forwarded on the next edge
    assert_release_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && cond_n) |=> btn_n);

endmodule

// File: rtl/pwrbtn_gate.sv
module pwrbtn_gate #(
    parameter int unsigned CONFIRM_CYCLES = 500000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_n,
    input  logic       lid_open,
    input  logic       ac_absent,
    input  logic [2:0] plat_state,
    input  logic       seq_busy,
    output logic       btn_n,
    output logic       pwrup_req,
    output logic       spurious
);
    localparam int unsigned SENSE_W = 3;

    logic [SENSE_W-1:0] sense_s;
    logic sw_s, lid_s, ac_abs_s;
    logic masked;
    logic cond_n;
    logic tmr_start, tmr_running, tmr_expire;

    pwrbtn_sync #(
        .WIDTH   (SENSE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({SENSE_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sw_n, lid_open, ac_absent}),
        .q     (sense_s)
    );

    assign {sw_s, lid_s, ac_abs_s} = sense_s;
    assign masked = !lid_s && ac_abs_s;
    assign cond_n = sw_s || masked;

    pwrbtn_timer #(
        .CYCLES (CONFIRM_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    pwrbtn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_n      (cond_n),
        .plat_state  (plat_state),
        .seq_busy    (seq_busy),
        .tmr_running (tmr_running),
        .tmr_expire  (tmr_expire),
        .tmr_start   (tmr_start),
        .btn_n       (btn_n),
        .pwrup_req   (pwrup_req),
        .spurious    (spurious)
    );

    // R5: no second wait is started while one is running
    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_running |-> !tmr_start);

    // R2: a shut lid without adapter never lets a new wait begin
    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> !tmr_start);

endmodule

// File: tb/pwrbtn_gate_tb.sv
`timescale 1ns/1ps
module pwrbtn_gate_tb;

    localparam int N = 40;
    localparam logic [2:0] PS_DEEP = 3'b001;
    localparam logic [2:0] PS_ON   = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_n = 1'b1;
    logic       lid_open = 1'b1;
    logic       ac_absent = 1'b0;
    logic [2:0] plat_state = PS_ON;
    logic       seq_busy = 1'b0;
    logic       btn_n, pwrup_req, spurious;

    int n_checks = 0;
    int n_fail = 0;
    int spur_cnt = 0;
    int low_cnt = 0;
    int req_rise = 0;
    logic req_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwrbtn_gate #(.CONFIRM_CYCLES(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_n(sw_n), .lid_open(lid_open),
        .ac_absent(ac_absent), .plat_state(plat_state), .seq_busy(seq_busy),
        .btn_n(btn_n), .pwrup_req(pwrup_req), .spurious(spurious)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (spurious) spur_cnt++;
            if (!btn_n) low_cnt++;
            if (pwrup_req && !req_prev) req_rise++;
            req_prev <= pwrup_req;
        end
    end

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 btn_n after reset", btn_n, 1);
        check("R1 pwrup_req after reset", pwrup_req, 0);
        check("R1 spurious after reset", spurious, 0);
    endtask

    task automatic t_press_on();
        plat_state = PS_ON; lid_open = 1'b1; ac_absent = 1'b0;
        cyc(4);
        sw_n = 1'b0;
        cyc(N - 2);
        check("R3 btn_n high during wait", btn_n, 1);
        cyc(10);
        check("R8 btn_n low after confirm", btn_n, 0);
        check("R8 no power-up request", req_rise, 0);
        sw_n = 1'b1;
        cyc(4);
        check("R9 release forwarded", btn_n, 1);
        cyc(4);
    endtask

    task automatic t_glitch();
        int s0 = spur_cnt;
        int l0 = low_cnt;
        sw_n = 1'b0; cyc(3); sw_n = 1'b1;
        cyc(N + 10);
        check("R4 glitch flagged once", spur_cnt - s0, 1);
        check("R4 glitch not forwarded", low_cnt - l0, 0);
    endtask

    task automatic t_bounce();
        int s0 = spur_cnt;
        sw_n = 1'b0; cyc(15);
        sw_n = 1'b1; cyc(3);
        sw_n = 1'b0; cyc(N + 8 - 18);
        check("R5 decision at first-press time", btn_n, 0);
        check("R5 no rejection for held press", spur_cnt - s0, 0);
        sw_n = 1'b1; cyc(6);
        check("R9 release after bounce", btn_n, 1);
    endtask

    task automatic t_bounce_release();
        int s0 = spur_cnt;
        int l0 = low_cnt;
        sw_n = 1'b0; cyc(20);
        sw_n = 1'b1; cyc(N + 10);
        check("R4 bounce ending released flagged", spur_cnt - s0, 1);
        check("R4 bounce ending released not forwarded", low_cnt - l0, 0);
    endtask

    task automatic t_mask();
        int s0, l0;
        lid_open = 1'b0; ac_absent = 1'b1; cyc(4);
        s0 = spur_cnt; l0 = low_cnt;
        sw_n = 1'b0; cyc(2 * N);
        check("R2 masked press not forwarded", low_cnt - l0, 0);
        check("R2 masked press not flagged", spur_cnt - s0, 0);
        sw_n = 1'b1; cyc(4);
        ac_absent = 1'b0; cyc(4);
        sw_n = 1'b0; cyc(N + 8);
        check("R2 lid shut with adapter passes press", btn_n, 0);
        sw_n = 1'b1; cyc(4);
        lid_open = 1'b1; ac_absent = 1'b1; cyc(4);
        sw_n = 1'b0; cyc(N + 8);
        check("R2 lid open without adapter passes press", btn_n, 0);
        sw_n = 1'b1; cyc(6);
        ac_absent = 1'b0;
        cyc(4);
    endtask

    task automatic t_mask_mid_wait();
        int s0 = spur_cnt;
        int l0 = low_cnt;
        sw_n = 1'b0; cyc(10);
        lid_open = 1'b0; ac_absent = 1'b1;
        cyc(N + 10);
        check("R2 mask during wait rejects press", spur_cnt - s0, 1);
        check("R2 mask during wait not forwarded", low_cnt - l0, 0);
        sw_n = 1'b1; lid_open = 1'b1; ac_absent = 1'b0;
        cyc(6);
    endtask

    task automatic t_standby();
        int seen = 0;
        int held = 1;
        int r0 = req_rise;
        plat_state = PS_DEEP;
        cyc(2);
        sw_n = 1'b0;
        for (int i = 0; i < N + 20; i++) begin
            @(negedge clk);
            if (pwrup_req) begin seen = 1; break; end
        end
        check("R6 request raised in standby", seen, 1);
        check("R7 button held at request", btn_n, 1);
        cyc(3);
        check("R6 request held until busy", pwrup_req, 1);
        seq_busy = 1'b1;
        cyc(2);
        check("R6 request dropped after busy", pwrup_req, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!btn_n) held = 0;
        end
        check("R7 button held while busy", held, 1);
        seq_busy = 1'b0;
        cyc(1);
        check("R7 press forwarded after busy", btn_n, 0);
        check("R6 single request", req_rise - r0, 1);
        sw_n = 1'b1; plat_state = PS_ON;
        cyc(5);
        check("R9 release after power-up", btn_n, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_press_on();
        t_glitch();
        t_bounce();
        t_bounce_release();
        t_mask();
        t_mask_mid_wait();
        t_standby();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule